// File: doc/BRIEF.md
# Dual-Rate Row Refresh Controller

This block decides how often each row of a small memory is refreshed, and it issues those refreshes one at a time. Each row carries a two-bit rate state. After reset every row is refreshed at the conservative high rate. An external checker examines rows one at a time, using whatever data the row holds at that moment. The block asks for each untested row to be examined. A row that comes back clean drops to the low rate. A row that comes back with an error stays at the high rate for good.

Refresh requests leave on a valid/ready channel. A scan pointer walks the rows in a ring and raises a request for the first row whose age has reached its period. The request is held until it is accepted. The high period is a cycle count taken from an input. The low period is that count times a multiplier input. A write to a row that passed, or that is under test, sends the row back to untested, because its content has changed. Population counts per state and a running count of issued refreshes are output, so the saving in refresh traffic can be measured.

Top module: `dual_rate_refresh`

## Requirements
- R1: After reset all ROWS rows are untested: n_untested_o = ROWS, the other three counts are 0, ref_valid_o = 0 and ref_count_o = 0.
- R2: chk_req_valid_o is high exactly when no row is under test and at least one row is untested. chk_req_row_o names the lowest-index untested row. A handshake moves that row to under-test, visible in the counts on the next cycle. At most one row is under test at any time.
- R3: A result (chk_res_valid_i) for the row under test moves it to passed when chk_res_fail_i = 0, and to failed when chk_res_fail_i = 1. A result for a row that is not under test changes no state.
- R4: A write (wr_valid_i, wr_row_i) to a passed row or to a row under test returns that row to untested. A write to an untested or failed row has no effect.
- R5: No refresh request is raised within hi_period_i cycles after reset. Untested, under-test and failed rows become due hi_period_i cycles after their last refresh. Passed rows become due hi_period_i × lo_mult_i cycles after it (lo_mult_i ≥ 1).
- R6: While ref_valid_o is high and ref_ready_i is low, ref_valid_o stays high and ref_row_o stays unchanged.
- R7: When every row runs at the same rate, accepted refreshes visit the rows in ascending index order, wrapping from ROWS-1 to 0.
- R8: ref_count_o rises by exactly one on each accepted refresh and is otherwise unchanged. The four state counts always sum to ROWS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hi_period_i | input | PER_W | High-rate refresh period in cycles |
| lo_mult_i | input | MUL_W | Low period as a multiple of the high period |
| wr_valid_i | input | 1 | A row's content was written this cycle |
| wr_row_i | input | ROW_W | Row written |
| chk_req_valid_o | output | 1 | A row awaits a content check |
| chk_req_row_o | output | ROW_W | Row to check |
| chk_req_ready_i | input | 1 | Checker takes the request |
| chk_res_valid_i | input | 1 | Check result present |
| chk_res_row_i | input | ROW_W | Row the result is for |
| chk_res_fail_i | input | 1 | 1 = error found in the row |
| ref_valid_o | output | 1 | Refresh request present |
| ref_row_o | output | ROW_W | Row to refresh |
| ref_ready_i | input | 1 | Refresh accepted |
| ref_count_o | output | RCNT_W | Accepted refreshes since reset |
| n_untested_o | output | NCNT_W | Rows untested |
| n_testing_o | output | NCNT_W | Rows under test |
| n_passed_o | output | NCNT_W | Rows at the low rate |
| n_failed_o | output | NCNT_W | Rows failed, kept at the high rate |

## Verification
Handshakes, results and writes are held across one rising edge. Their effect on the state counts, and on the check request derived from those counts, is therefore read at the following falling edge, one register later.

An accepted refresh changes ref_count_o at that same edge, and the bench reads it at the next falling edge. A row's first request cannot appear before hi_period_i + 1 edges, since the age register and the request register each add one. The bench therefore asserts silence only over a shorter window.

The rate checks allow for the scan latency by bounding each row's refresh count over a long window. The lower bound uses the period plus three times the row count, and the upper bound uses the bare period.

// File: rtl/drr_pkg.sv
package drr_pkg;
  typedef enum logic [1:0] {
    ST_UNTESTED = 2'd0,
    ST_TESTING  = 2'd1,
    ST_PASSED   = 2'd2,
    ST_FAILED   = 2'd3
  } row_st_e;
endpackage

// File: rtl/drr_row.sv
module drr_row #(
  parameter int PER_W = 12,
  parameter int MUL_W = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [PER_W-1:0]    hi_period_i,
  input  logic [MUL_W-1:0]    lo_mult_i,
  input  logic                wr_hit_i,
  input  logic                chk_take_i,
  input  logic                res_hit_i,
  input  logic                res_fail_i,
  input  logic                ref_done_i,
  output drr_pkg::row_st_e    state_o,
  output logic                due_o
);
  import drr_pkg::*;
  localparam int AGE_W = PER_W + MUL_W;

  row_st_e          state_q, state_d;
  logic [AGE_W-1:0] age_q, period;

  always_comb begin
    if (state_q == ST_PASSED) period = AGE_W'(hi_period_i) * AGE_W'(lo_mult_i);
    else                      period = AGE_W'(hi_period_i);
  end

  assign due_o   = age_q >= period;
  assign state_o = state_q;

  // write beats check start and result: content changed, recheck needed
  always_comb begin
    state_d = state_q;
    if (wr_hit_i && (state_q == ST_PASSED || state_q == ST_TESTING))
      state_d = ST_UNTESTED;
    else if (chk_take_i && state_q == ST_UNTESTED)
      state_d = ST_TESTING;
    else if (res_hit_i && state_q == ST_TESTING)
      state_d = res_fail_i ? ST_FAILED : ST_PASSED;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_UNTESTED;
      age_q   <= '0;
    end else begin
      state_q <= state_d;
      if (ref_done_i)        age_q <= '0;
      else if (age_q != '1)  age_q <= age_q + AGE_W'(1);
    end
  end
endmodule

// File: rtl/drr_chk_pick.sv
module drr_chk_pick #(
  parameter int ROWS = 4,
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic [ROWS-1:0]  untested_i,
  input  logic             busy_i,
  output logic             valid_o,
  output logic [ROW_W-1:0] row_o
);
  assign valid_o = (|untested_i) && !busy_i;

  always_comb begin
    row_o = '0;
    for (int i = ROWS - 1; i >= 0; i--)
      if (untested_i[i]) row_o = ROW_W'(i);
  end
endmodule

// File: rtl/drr_ref_scan.sv
module drr_ref_scan #(
  parameter int ROWS = 4,
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ROWS-1:0]  due_i,
  input  logic             ready_i,
  output logic             valid_o,
  output logic [ROW_W-1:0] row_o,
  output logic [ROWS-1:0]  done_o
);
  logic [ROW_W-1:0] ptr_q;
  logic             valid_q;
  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q   <= '0;
      valid_q <= 1'b0;
      row_q   <= '0;
    end else if (valid_q) begin
      if (ready_i) valid_q <= 1'b0;
    end else begin
      if (due_i[ptr_q]) begin
        valid_q <= 1'b1;
        row_q   <= ptr_q;
      end
      ptr_q <= (ptr_q == ROW_W'(ROWS - 1)) ? '0 : ptr_q + ROW_W'(1);
    end
  end

  always_comb
    for (int i = 0; i < ROWS; i++)
      done_o[i] = valid_q && ready_i && (row_q == ROW_W'(i));

  assign valid_o = valid_q;
  assign row_o   = row_q;
endmodule

// File: rtl/dual_rate_refresh.sv
module dual_rate_refresh #(
  parameter int ROWS   = 4,
  parameter int PER_W  = 12,
  parameter int MUL_W  = 3,
  parameter int RCNT_W = 24,
  localparam int ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int NCNT_W = $clog2(ROWS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PER_W-1:0]  hi_period_i,
  input  logic [MUL_W-1:0]  lo_mult_i,
  input  logic              wr_valid_i,
  input  logic [ROW_W-1:0]  wr_row_i,
  output logic              chk_req_valid_o,
  output logic [ROW_W-1:0]  chk_req_row_o,
  input  logic              chk_req_ready_i,
  input  logic              chk_res_valid_i,
  input  logic [ROW_W-1:0]  chk_res_row_i,
  input  logic              chk_res_fail_i,
  output logic              ref_valid_o,
  output logic [ROW_W-1:0]  ref_row_o,
  input  logic              ref_ready_i,
  output logic [RCNT_W-1:0] ref_count_o,
  output logic [NCNT_W-1:0] n_untested_o,
  output logic [NCNT_W-1:0] n_testing_o,
  output logic [NCNT_W-1:0] n_passed_o,
  output logic [NCNT_W-1:0] n_failed_o
);
  import drr_pkg::*;

  row_st_e           row_st [ROWS];
  logic [ROWS-1:0]   due, done, untested, testing;
  logic [RCNT_W-1:0] ref_cnt_q;

  for (genvar g = 0; g < ROWS; g++) begin : g_row
    drr_row #(.PER_W(PER_W), .MUL_W(MUL_W)) u_row (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .hi_period_i (hi_period_i),
      .lo_mult_i   (lo_mult_i),
      .wr_hit_i    (wr_valid_i && (wr_row_i == ROW_W'(g))),
      .chk_take_i  (chk_req_valid_o && chk_req_ready_i && (chk_req_row_o == ROW_W'(g))),
      .res_hit_i   (chk_res_valid_i && (chk_res_row_i == ROW_W'(g))),
      .res_fail_i  (chk_res_fail_i),
      .ref_done_i  (done[g]),
      .state_o     (row_st[g]),
      .due_o       (due[g])
    );
    assign untested[g] = row_st[g] == ST_UNTESTED;
    assign testing[g]  = row_st[g] == ST_TESTING;
  end

  drr_chk_pick #(.ROWS(ROWS)) u_pick (
    .untested_i (untested),
    .busy_i     (|testing),
    .valid_o    (chk_req_valid_o),
    .row_o      (chk_req_row_o)
  );

  drr_ref_scan #(.ROWS(ROWS)) u_scan (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .due_i   (due),
    .ready_i (ref_ready_i),
    .valid_o (ref_valid_o),
    .row_o   (ref_row_o),
    .done_o  (done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        ref_cnt_q <= '0;
    else if (ref_valid_o && ref_ready_i) ref_cnt_q <= ref_cnt_q + RCNT_W'(1);
  end
  assign ref_count_o = ref_cnt_q;

  always_comb begin
    n_untested_o = '0;
    n_testing_o  = '0;
    n_passed_o   = '0;
    n_failed_o   = '0;
    for (int i = 0; i < ROWS; i++) begin
      unique case (row_st[i])
        ST_UNTESTED: n_untested_o = n_untested_o + NCNT_W'(1);
        ST_TESTING:  n_testing_o  = n_testing_o  + NCNT_W'(1);
        ST_PASSED:   n_passed_o   = n_passed_o   + NCNT_W'(1);
        ST_FAILED:   n_failed_o   = n_failed_o   + NCNT_W'(1);
      endcase
    end
  end
endmodule

// File: rtl/drr_checker.sv
module drr_checker #(
  parameter int ROWS   = 4,
  parameter int RCNT_W = 24,
  localparam int ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int NCNT_W = $clog2(ROWS + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_valid_i,
  input logic              chk_req_valid_o,
  input logic              chk_req_ready_i,
  input logic              chk_res_valid_i,
  input logic              ref_valid_o,
  input logic [ROW_W-1:0]  ref_row_o,
  input logic              ref_ready_i,
  input logic [RCNT_W-1:0] ref_count_o,
  input logic [NCNT_W-1:0] n_untested_o,
  input logic [NCNT_W-1:0] n_testing_o,
  input logic [NCNT_W-1:0] n_passed_o,
  input logic [NCNT_W-1:0] n_failed_o
);
  p_sum_rows_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(n_untested_o) + int'(n_testing_o) + int'(n_passed_o) + int'(n_failed_o) == ROWS);

  p_one_testing_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    n_testing_o <= NCNT_W'(1));

  p_req_cond_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_req_valid_o |-> (n_testing_o == '0) && (n_untested_o != '0));

  p_take_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_req_valid_o && chk_req_ready_i && !wr_valid_i |=> n_testing_o == NCNT_W'(1));

  p_stray_result_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_res_valid_i && (n_testing_o == '0) && !wr_valid_i && !chk_req_ready_i
      |=> $stable(n_passed_o) && $stable(n_failed_o));

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_valid_o && !ref_ready_i |=> ref_valid_o && $stable(ref_row_o));

  p_count_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_valid_o && ref_ready_i |=> ref_count_o == $past(ref_count_o) + RCNT_W'(1));

  p_count_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ref_valid_o && ref_ready_i) |=> $stable(ref_count_o));
endmodule

bind dual_rate_refresh drr_checker #(.ROWS(ROWS), .RCNT_W(RCNT_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .wr_valid_i      (wr_valid_i),
  .chk_req_valid_o (chk_req_valid_o),
  .chk_req_ready_i (chk_req_ready_i),
  .chk_res_valid_i (chk_res_valid_i),
  .ref_valid_o     (ref_valid_o),
  .ref_row_o       (ref_row_o),
  .ref_ready_i     (ref_ready_i),
  .ref_count_o     (ref_count_o),
  .n_untested_o    (n_untested_o),
  .n_testing_o     (n_testing_o),
  .n_passed_o      (n_passed_o),
  .n_failed_o      (n_failed_o)
);

// File: tb/sim_dual_rate_refresh.sv
module sim_dual_rate_refresh;
  localparam int ROWS = 4;
  localparam int HI   = 20;
  localparam int MULT = 4;
  localparam int WIN  = 2400;
  localparam int SL   = 3 * ROWS;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] hi_period_i = 12'(HI);
  logic [2:0]  lo_mult_i = 3'(MULT);
  logic        wr_valid_i = 1'b0;
  logic [1:0]  wr_row_i = '0;
  logic        chk_req_valid_o;
  logic [1:0]  chk_req_row_o;
  logic        chk_req_ready_i = 1'b0;
  logic        chk_res_valid_i = 1'b0;
  logic [1:0]  chk_res_row_i = '0;
  logic        chk_res_fail_i = 1'b0;
  logic        ref_valid_o;
  logic [1:0]  ref_row_o;
  logic        ref_ready_i = 1'b1;
  logic [23:0] ref_count_o;
  logic [2:0]  n_untested_o, n_testing_o, n_passed_o, n_failed_o;

  dual_rate_refresh u0 (.*);

  always #5 clk_i = ~clk_i;

  int n_chk = 0, n_bad = 0;
  int hs_cnt [ROWS];
  int hs_total = 0, order_err = 0;
  logic order_en = 1'b0, have_prev = 1'b0;
  logic [1:0] prev_row = '0;
  int cyc = 0;
  logic done_flag = 1'b0;

  initial for (int i = 0; i < ROWS; i++) hs_cnt[i] = 0;

  // handshake monitor: registered outputs and inputs held since the falling edge
  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (rst_ni && ref_valid_o && ref_ready_i) begin
      hs_cnt[ref_row_o] <= hs_cnt[ref_row_o] + 1;
      hs_total <= hs_total + 1;
      if (order_en && have_prev && ref_row_o != prev_row + 2'd1) order_err <= order_err + 1;
      prev_row  <= ref_row_o;
      have_prev <= order_en;
    end
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_counts(input string tag, input int u, input int t, input int p, input int f);
    check(n_untested_o == 3'(u), {tag, " untested"}, n_untested_o, u);
    check(n_testing_o  == 3'(t), {tag, " testing"},  n_testing_o,  t);
    check(n_passed_o   == 3'(p), {tag, " passed"},   n_passed_o,   p);
    check(n_failed_o   == 3'(f), {tag, " failed"},   n_failed_o,   f);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic grant(input int row, input string tag);
    check(chk_req_valid_o && chk_req_row_o == 2'(row), {tag, " chk_req row"},
          chk_req_valid_o ? int'(chk_req_row_o) : -1, row);
    chk_req_ready_i = 1'b1;
    @(negedge clk_i);
    chk_req_ready_i = 1'b0;
  endtask

  task automatic result(input int row, input logic fail);
    chk_res_valid_i = 1'b1; chk_res_row_i = 2'(row); chk_res_fail_i = fail;
    @(negedge clk_i);
    chk_res_valid_i = 1'b0; chk_res_fail_i = 1'b0;
  endtask

  task automatic write_row(input int row);
    wr_valid_i = 1'b1; wr_row_i = 2'(row);
    @(negedge clk_i);
    wr_valid_i = 1'b0;
  endtask

  // {op[1:0] 0=grant 1=result 2=write, row[1:0], fail, exp untested, testing, passed, failed}
  localparam logic [16:0] TBL [16] = '{
    {2'd0, 2'd0, 1'b0, 3'd3, 3'd1, 3'd0, 3'd0},
    {2'd1, 2'd0, 1'b0, 3'd3, 3'd0, 3'd1, 3'd0},
    {2'd0, 2'd1, 1'b0, 3'd2, 3'd1, 3'd1, 3'd0},
    {2'd1, 2'd2, 1'b1, 3'd2, 3'd1, 3'd1, 3'd0},
    {2'd1, 2'd1, 1'b1, 3'd2, 3'd0, 3'd1, 3'd1},
    {2'd2, 2'd1, 1'b0, 3'd2, 3'd0, 3'd1, 3'd1},
    {2'd2, 2'd0, 1'b0, 3'd3, 3'd0, 3'd0, 3'd1},
    {2'd0, 2'd0, 1'b0, 3'd2, 3'd1, 3'd0, 3'd1},
    {2'd2, 2'd0, 1'b0, 3'd3, 3'd0, 3'd0, 3'd1},
    {2'd1, 2'd0, 1'b0, 3'd3, 3'd0, 3'd0, 3'd1},
    {2'd0, 2'd0, 1'b0, 3'd2, 3'd1, 3'd0, 3'd1},
    {2'd1, 2'd0, 1'b0, 3'd2, 3'd0, 3'd1, 3'd1},
    {2'd0, 2'd2, 1'b0, 3'd1, 3'd1, 3'd1, 3'd1},
    {2'd1, 2'd2, 1'b0, 3'd1, 3'd0, 3'd2, 3'd1},
    {2'd0, 2'd3, 1'b0, 3'd0, 3'd1, 3'd2, 3'd1},
    {2'd1, 2'd3, 1'b0, 3'd0, 3'd0, 3'd3, 3'd1}
  };

  initial begin : watchdog
    wait (cyc > 100000);
    if (!done_flag) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin : main
    int seen, cnt0, snap [ROWS], tot0;
    logic [1:0] held;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    check_counts("R1", ROWS, 0, 0, 0);
    check(!ref_valid_o, "R1 ref_valid", ref_valid_o, 0);
    check(ref_count_o == 0, "R1 ref_count", ref_count_o, 0);
    check(chk_req_valid_o && chk_req_row_o == 0, "R2 first request row0", chk_req_row_o, 0);

    // R5 no refresh before hi period elapses
    seen = 0;
    for (int i = 0; i < HI - 2; i++) begin
      @(negedge clk_i);
      if (ref_valid_o) seen++;
    end
    check(seen == 0, "R5 early refresh", seen, 0);

    // R7 ascending round-robin with all rows at high rate
    order_en = 1'b1;
    cnt0 = hs_total;
    wait (hs_total >= cnt0 + 40);
    @(negedge clk_i);
    order_en = 1'b0;
    check(order_err == 0, "R7 order errors", order_err, 0);

    // R6 hold while stalled, R8 single increment on accept
    ref_ready_i = 1'b0;
    while (!ref_valid_o) @(negedge clk_i);
    held = ref_row_o;
    seen = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_i);
      if (!ref_valid_o || ref_row_o != held) seen++;
    end
    check(seen == 0, "R6 hold under stall", seen, 0);
    cnt0 = int'(ref_count_o);
    ref_ready_i = 1'b1;
    @(negedge clk_i);
    check(int'(ref_count_o) == cnt0 + 1, "R8 count step", ref_count_o, cnt0 + 1);

    // table: checks, results, writes (R2 R3 R4)
    do_reset();
    for (int k = 0; k < 16; k++) begin
      logic [16:0] e;
      string tg;
      e = TBL[k];
      tg = (e[16:15] == 2'd0) ? "R2" : (e[16:15] == 2'd1) ? "R3" : "R4";
      case (e[16:15])
        2'd0: grant(int'(e[14:13]), tg);
        2'd1: result(int'(e[14:13]), e[12]);
        default: write_row(int'(e[14:13]));
      endcase
      check_counts($sformatf("%s step%0d", tg, k), int'(e[11:9]), int'(e[8:6]), int'(e[5:3]), int'(e[2:0]));
    end
    check(!chk_req_valid_o, "R2 no request when all tested", chk_req_valid_o, 0);

    // rate: rows 0,1 passed (low), row 2 failed, row 3 untested (R5)
    do_reset();
    grant(0, "R2"); result(0, 1'b0);
    grant(1, "R2"); result(1, 1'b0);
    grant(2, "R2"); result(2, 1'b1);
    check_counts("R3 rate setup", 1, 0, 2, 1);
    for (int i = 0; i < ROWS; i++) snap[i] = hs_cnt[i];
    tot0 = int'(ref_count_o);
    cnt0 = hs_total;
    repeat (WIN) @(negedge clk_i);
    for (int i = 0; i < ROWS; i++) begin
      int n, lo_b, hi_b;
      int per;
      per  = (i < 2) ? HI * MULT : HI;
      n    = hs_cnt[i] - snap[i];
      lo_b = WIN / (per + SL);
      hi_b = WIN / per + 1;
      check(n >= lo_b && n <= hi_b, $sformatf("R5 row%0d refresh count", i), n, per);
    end
    check(int'(ref_count_o) - tot0 == hs_total - cnt0, "R8 count matches handshakes",
          int'(ref_count_o) - tot0, hs_total - cnt0);

    done_flag = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule